// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Store Access Controller

This block connects a simple CPU register interface to a byte-wide nonvolatile data array. The array is modelled here as a register array. Software loads an address register and a data register, then pulses a read or a write strobe. Each accepted access raises a CPU stall output for a fixed number of cycles, and reads and writes use different counts. A read places the addressed byte in the data register before the stall ends. A write copies the address and data into a commit latch and then runs on a self-timed counter. While that counter runs, a busy flag is raised that software can poll.

The block also takes a level power-down request and drives a clock-request output. An idle block lets the clock stop on the cycle after the request arrives. A request that arrives while a write is in flight does not interrupt the write. The clock request then stays high for as long as that request is held, even after the write has finished, so the power-down never takes hold until the request is withdrawn.

No data stream crosses this block's edge, so none of its ports uses a valid/ready handshake. The stall output is the only back-pressure: while it is high, the CPU must not advance, and register loads presented to the block are dropped.

Top module: `nvbyte_ctrl`

## Requirements
- R1: A synchronous active-high reset clears stall, busy and err, and sets clk_req to 1 and addr_q and data_q to 0. Array contents survive a reset.
- R2: A read strobe accepted at a clock edge holds stall high for exactly RD_STALL (default 4) cycles, starting in the cycle after the strobe. The addressed byte appears on data_q during the last of those cycles.
- R3: A write strobe accepted at a clock edge holds stall high for exactly WR_STALL (default 2) cycles, starting in the cycle after the strobe. data_q is left unchanged.
- R4: After an accepted write, busy is high for exactly WRITE_CYCLES cycles, starting in the cycle after the strobe. The addressed location holds the new byte from the cycle in which busy falls.
- R5: A strobe is accepted only when busy and stall are both low. Any other strobe is ignored and sets err, which stays set until reset. An ignored write leaves its target location unchanged.
- R6: If rd_strobe and wr_strobe are both high in an idle cycle, only the read is performed: busy stays low and the stall lasts RD_STALL cycles.
- R7: addr_we and data_we take effect at the next edge only while stall is low. While stall is high they are ignored.
- R8: With pd_req high, no write in flight, and no earlier hold in force, clk_req is 0 from the next cycle. It returns to 1 in the cycle after pd_req falls.
- R9: If pd_req is high in any cycle in which busy is high, the write completes normally, and clk_req stays 1 until pd_req has been low for one clock edge.
- R10: The array holds 2^ADDR_W bytes (default 2048). The lowest location (0) and the highest location (2^ADDR_W - 1) are stored independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_we | input | 1 | Load the address register |
| addr_wdata | input | ADDR_W | New address value |
| data_we | input | 1 | Load the data register |
| data_wdata | input | DATA_W | New data value |
| rd_strobe | input | 1 | Start a read |
| wr_strobe | input | 1 | Start a write |
| pd_req | input | 1 | Power-down request (level) |
| addr_q | output | ADDR_W | Address register contents |
| data_q | output | DATA_W | Data register contents |
| stall | output | 1 | CPU stall |
| busy | output | 1 | Self-timed write in progress |
| err | output | 1 | Sticky flag: a strobe was ignored |
| clk_req | output | 1 | Clock must keep running |

## Verification
The bench keeps the default ADDR_W of 11, so both the lowest and the highest of the 2048 locations can be written and read back. It uses RD_STALL 4 and WR_STALL 2 as they stand. It shortens WRITE_CYCLES to 16, which lets several complete writes fit in one run, including a power-down request held across a write and past its end and a strobe issued while busy is high. Because WR_STALL is shorter than the write time, the bench can also reach the window in which stall is low and busy is still high.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } nvb_op_e;
endpackage

// File: rtl/nvb_stall_seq.sv
module nvb_stall_seq
  import nvb_pkg::*;
#(
  parameter int RD_STALL = 4,
  parameter int WR_STALL = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_rd,
  input  logic start_wr,
  output logic stall,
  output logic rd_capture
);
  localparam int SMAX = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int CW   = $clog2(SMAX + 1);

  logic [CW-1:0] cnt_q;
  nvb_op_e       op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      op_q  <= OP_RD;
    end else if (start_rd) begin
      cnt_q <= CW'(RD_STALL);
      op_q  <= OP_RD;
    end else if (start_wr) begin
      cnt_q <= CW'(WR_STALL);
      op_q  <= OP_WR;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign stall      = (cnt_q != '0);
  // capture one edge before the final stall cycle so data is shown in it
  assign rd_capture = (op_q == OP_RD) && (cnt_q == CW'(2));

  assert_no_restart_R5: assert property (@(posedge clk) disable iff (rst)
    stall |-> !(start_rd || start_wr));
endmodule

// File: rtl/nvb_write_timer.sv
module nvb_write_timer #(
  parameter int WRITE_CYCLES = 64,
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              busy,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  localparam int TW = $clog2(WRITE_CYCLES + 1);

  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q <= '0;
    end else if (start) begin
      tmr_q <= TW'(WRITE_CYCLES);
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      commit_addr <= addr_in;
      commit_data <= data_in;
    end
  end

  assign busy   = (tmr_q != '0);
  assign commit = (tmr_q == TW'(1));

  assert_latch_held_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !start) |=> ($stable(commit_addr) && $stable(commit_data)));
endmodule

// File: rtl/nvb_array.sv
module nvb_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/nvb_sleep_gate.sv
module nvb_sleep_gate (
  input  logic clk,
  input  logic rst,
  input  logic pd_req,
  input  logic busy,
  output logic clk_req
);
  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q   <= 1'b0;
      clk_req <= 1'b1;
    end else begin
      pin_q   <= pd_req && (pin_q || busy);
      clk_req <= !(pd_req && !busy && !pin_q);
    end
  end

  assert_write_keeps_clock_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> clk_req);
endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl #(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 64,
  parameter int RD_STALL     = 4,
  parameter int WR_STALL     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_wdata,
  input  logic              rd_strobe,
  input  logic              wr_strobe,
  input  logic              pd_req,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              stall,
  output logic              busy,
  output logic              err,
  output logic              clk_req
);
  localparam int SMAX  = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
  localparam int RUN_W = $clog2(SMAX + 2);

  logic              idle, acc_rd, acc_wr, rd_capture, commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [DATA_W-1:0] commit_data, rdata;

  assign idle   = !busy && !stall;
  assign acc_rd = idle && rd_strobe;
  assign acc_wr = idle && wr_strobe && !rd_strobe;

  nvb_stall_seq #(.RD_STALL(RD_STALL), .WR_STALL(WR_STALL)) u_stall (
    .clk(clk), .rst(rst), .start_rd(acc_rd), .start_wr(acc_wr),
    .stall(stall), .rd_capture(rd_capture)
  );

  nvb_write_timer #(.WRITE_CYCLES(WRITE_CYCLES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_timer (
    .clk(clk), .rst(rst), .start(acc_wr), .addr_in(addr_q), .data_in(data_q),
    .busy(busy), .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  nvb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(commit), .waddr(commit_addr), .wdata(commit_data),
    .raddr(addr_q), .rdata(rdata)
  );

  nvb_sleep_gate u_sleep (
    .clk(clk), .rst(rst), .pd_req(pd_req), .busy(busy), .clk_req(clk_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
      err    <= 1'b0;
    end else begin
      if (addr_we && !stall) addr_q <= addr_wdata;
      if (rd_capture)             data_q <= rdata;
      else if (data_we && !stall) data_q <= data_wdata;
      if ((rd_strobe || wr_strobe) && !idle) err <= 1'b1;
    end
  end

  // length of the most recent stall run, checked when it ends
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= stall ? run_q + 1'b1 : '0;
  end

  assert_stall_len_R2: assert property (@(posedge clk) disable iff (rst)
    (!stall && run_q != '0) |-> (run_q == RUN_W'(RD_STALL) || run_q == RUN_W'(WR_STALL)));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_busy_starts_stalled_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> stall);

  assert_stall_freezes_addr_R7: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(addr_q));
endmodule

// File: tb/nvbyte_ctrl_tb.sv
module nvbyte_ctrl_tb;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int WC = 16;
  localparam int RS = 4;
  localparam int WS = 2;

  logic clk = 0;
  logic rst = 1;
  logic addr_we = 0, data_we = 0, rd_strobe = 0, wr_strobe = 0, pd_req = 0;
  logic [AW-1:0] addr_wdata = '0;
  logic [DW-1:0] data_wdata = '0;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic stall, busy, err, clk_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nvbyte_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WRITE_CYCLES(WC),
                .RD_STALL(RS), .WR_STALL(WS)) u_dut (
    .clk(clk), .rst(rst), .addr_we(addr_we), .addr_wdata(addr_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe), .pd_req(pd_req), .addr_q(addr_q), .data_q(data_q),
    .stall(stall), .busy(busy), .err(err), .clk_req(clk_req)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [DW-1:0] mmem [int];
  int m_stall = 0, m_busy = 0, m_addr = 0, m_data = 0, m_waddr = 0, m_wdata = 0;
  bit m_err = 0, m_clk = 1, m_pin = 0, m_rd = 0, started = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_stall = 0; m_busy = 0; m_err = 0; m_clk = 1; m_pin = 0;
      m_addr = 0; m_data = 0; started = 1;
    end else begin
      int s0, b0, a0, d0;
      bit idle;
      s0 = m_stall; b0 = m_busy; a0 = m_addr; d0 = m_data;
      idle = (s0 == 0) && (b0 == 0);
      if ((rd_strobe || wr_strobe) && !idle) m_err = 1;
      m_clk = !(pd_req && b0 == 0 && !m_pin);
      m_pin = pd_req && (m_pin || b0 != 0);
      if (s0 != 0) begin
        if (m_rd && s0 == 2) m_data = int'(mmem[m_addr]);
        m_stall = s0 - 1;
      end else begin
        if (addr_we) m_addr = int'(addr_wdata);
        if (data_we) m_data = int'(data_wdata);
      end
      if (b0 != 0) begin
        m_busy = b0 - 1;
        if (m_busy == 0) mmem[m_waddr] = DW'(m_wdata);
      end
      if (idle && rd_strobe) begin
        m_stall = RS; m_rd = 1;
      end else if (idle && wr_strobe) begin
        m_stall = WS; m_rd = 0; m_busy = WC; m_waddr = a0; m_wdata = d0;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check("R2/R3 stall", int'(stall), int'(m_stall != 0));
      check("R4 busy", int'(busy), int'(m_busy != 0));
      check("R5 err", int'(err), int'(m_err));
      check("R8/R9 clk_req", int'(clk_req), int'(m_clk));
      check("R7 addr_q", int'(addr_q), m_addr);
      check("R2 data_q", int'(data_q), m_data);
    end
  end

  task automatic load(int a, int d);
    @(negedge clk);
    addr_we = 1; addr_wdata = AW'(a); data_we = 1; data_wdata = DW'(d);
    @(negedge clk);
    addr_we = 0; data_we = 0;
  endtask

  task automatic do_write(int a, int d);
    int nb, ns;
    load(a, d);
    wr_strobe = 1;
    @(negedge clk);
    wr_strobe = 0;
    nb = 0; ns = 0;
    while (busy) begin
      nb++;
      if (stall) ns++;
      @(negedge clk);
    end
    check("R4 busy length", nb, WC);
    check("R3 write stall length", ns, WS);
  endtask

  task automatic do_read(int a, int exp);
    int ns, last;
    load(a, 0);
    rd_strobe = 1;
    @(negedge clk);
    rd_strobe = 0;
    ns = 0; last = -1;
    while (stall) begin
      ns++;
      last = int'(data_q);
      @(negedge clk);
    end
    check("R2 read stall length", ns, RS);
    check("R2 data on last stall cycle", last, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 stall", int'(stall), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 err", int'(err), 0);
    check("R1 clk_req", int'(clk_req), 1);
    check("R1 data_q", int'(data_q), 0);

    // R10 extreme locations, R4 writes
    do_write(0, 'h11);
    do_write((1 << AW) - 1, 'hA5);
    do_write(5, 'h3C);
    do_read((1 << AW) - 1, 'hA5);
    do_read(0, 'h11);
    do_read(5, 'h3C);

    // R3: data register unchanged by a write
    load(9, 'h5A);
    wr_strobe = 1;
    @(negedge clk);
    wr_strobe = 0;
    check("R3 data_q kept", int'(data_q), 'h5A);
    while (busy) @(negedge clk);

    // R6: both strobes in an idle cycle -> read only
    load(0, 'hFF);
    rd_strobe = 1; wr_strobe = 1;
    @(negedge clk);
    rd_strobe = 0; wr_strobe = 0;
    check("R6 no busy", int'(busy), 0);
    repeat (RS + 1) @(negedge clk);
    check("R6 read data", int'(data_q), 'h11);
    check("R6 err clear", int'(err), 0);

    // R7: loads during a read stall are dropped
    load(5, 0);
    rd_strobe = 1;
    @(negedge clk);
    rd_strobe = 0; addr_we = 1; addr_wdata = 'h123; data_we = 1; data_wdata = 'h77;
    @(negedge clk);
    addr_we = 0; data_we = 0;
    check("R7 addr held", int'(addr_q), 5);
    repeat (RS) @(negedge clk);
    check("R7 read unaffected", int'(data_q), 'h3C);

    // R8: idle power-down
    pd_req = 1;
    @(negedge clk);
    check("R8 clk_req low", int'(clk_req), 0);
    pd_req = 0;
    @(negedge clk);
    check("R8 clk_req back", int'(clk_req), 1);

    // R9: power-down during a write
    load(7, 'hC3);
    wr_strobe = 1;
    @(negedge clk);
    wr_strobe = 0;
    repeat (3) @(negedge clk);
    pd_req = 1;
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R9 clk_req held", int'(clk_req), 1);
    pd_req = 0;
    @(negedge clk);
    check("R9 clk_req after release", int'(clk_req), 1);
    pd_req = 1;
    @(negedge clk);
    check("R9 hold cleared", int'(clk_req), 0);
    pd_req = 0;
    @(negedge clk);
    do_read(7, 'hC3);

    // R5: strobe while busy ignored, err sticky
    load(12, 'h42);
    wr_strobe = 1;
    @(negedge clk);
    wr_strobe = 0;
    repeat (WS + 1) @(negedge clk);
    addr_we = 1; addr_wdata = 3; data_we = 1; data_wdata = 'h99;
    @(negedge clk);
    addr_we = 0; data_we = 0; wr_strobe = 1;
    @(negedge clk);
    wr_strobe = 0;
    check("R5 err set", int'(err), 1);
    while (busy) @(negedge clk);
    check("R5 no second write", int'(busy), 0);
    repeat (3) @(negedge clk);
    check("R5 err sticky", int'(err), 1);
    do_read(12, 'h42);
    do_write(3, 'h01);
    do_read(3, 'h01);

    // R1: reset keeps array
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 err cleared", int'(err), 0);
    check("R1 addr cleared", int'(addr_q), 0);
    do_read((1 << AW) - 1, 'hA5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule